// File: doc/BRIEF.md
# Link Speed Retrain Sequencer

This block raises a PCI Express link above the 2.5 GT/s base rate after the link first comes up. It runs by itself once reset is released, and runs again each time `start` is pulsed while it is finished. It first samples the link state machine code to confirm that the link is up. It then reads the port's supported-speed field and the link's current-speed field from the port's capability structure. If the port can go faster but the link is sitting at 2.5 GT/s, the block sets the retrain-link bit in link control with a read-modify-write. After that it watches training in two phases, and each phase has its own time limit.

All register traffic uses a simple request port. A request stays asserted, with address, direction and data held, until the register space answers with `rsp_valid`. The training itself is done elsewhere. The sequencer only issues register accesses and watches the state code. When a wait runs past its limit, a sticky error flag is set and the sequence carries on, so the block never hangs. `done` marks the end of every run, whether the run was skipped, completed, or timed out.

Top module: `link_retrain_seq`

## Requirements
- R1: The sequence starts by itself when reset is released. Once `done` is high, a one-cycle `start` runs it again. A `start` pulse during a run is ignored and issues no extra register access.
- R2: The link counts as up only when `ltssm_state` equals 0x0F. If the link is not up when a run begins, the run issues no register access and `done` rises two cycles after `start` is taken.
- R3: The block first reads the capability word at `CAP_BASE`+0x0C. If bits [3:0] of that word are 1 or less, the run ends after this single read.
- R4: The block next reads the status word at `CAP_BASE`+0x12. Unless bits [3:0] of that word equal 1 (2.5 GT/s), the run ends after these two reads.
- R5: To retrain, the block reads link control at `CAP_BASE`+0x10 and writes the same value back to that address with bit 5 set. All other bits are kept as read.
- R6: After the write, the block reads the status word repeatedly until bit 11 (training in progress) reads 0. Consecutive reads are separated by `POLL_GAP` idle cycles.
- R7: If bit 11 is still set on a read taken once at least `TRAIN_TIMEOUT` cycles have passed since the write completed, `err_train_timeout` is set and the block moves on to the link-up wait.
- R8: The link-up wait ends, with `done`, as soon as `ltssm_state` equals 0x0F. If that does not happen within `LINK_TIMEOUT` cycles, `err_link_timeout` is set and `done` is raised.
- R9: `done` is low during reset and while a run is active. It stays high from the end of a run until the next accepted `start`. Both error flags are cleared only by reset.
- R10: While `req_valid` is high and `rsp_valid` is low, `req_valid`, `req_write`, `req_addr` and `req_wdata` stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Rerun request, taken only while `done` is high |
| ltssm_state | input | 5 | Current link state machine code; 0x0F means up |
| req_valid | output | 1 | Register access pending |
| req_write | output | 1 | 1 for write, 0 for read |
| req_addr | output | ADDR_W | Byte address of the register |
| req_wdata | output | DATA_W | Write data |
| rsp_valid | input | 1 | Access complete; read data valid |
| rsp_rdata | input | DATA_W | Read data |
| done | output | 1 | Run finished |
| err_train_timeout | output | 1 | Sticky: training-status wait timed out |
| err_link_timeout | output | 1 | Sticky: link-up wait timed out |

## Verification
The bench exercises each boundary of the speed checks:
- A supported-speed code of exactly 1 and of 0. A design that compared with "below" instead of "at or below" would go on to read status and write control.
- A current speed of 5 GT/s. A design that retrained at any speed would issue an unwanted write.

It also covers the following cases:
- A control value that already has bits set, including the retrain bit. A design that dropped the read-modify-write would clobber neighbouring control bits.
- Training that never ends, and a link that never returns. A design without the time limits would hang, and the bench's timeout catches that.
- A stray `start` in the middle of a run. A design that accepted it would repeat its accesses.
- A clean run after an error. A design whose flags were not sticky would clear them during that run.

// File: rtl/link_retrain_seq.sv
module link_retrain_seq #(
  parameter int ADDR_W        = 12,
  parameter int DATA_W        = 16,
  parameter logic [ADDR_W-1:0] CAP_BASE = 'h080,
  parameter int POLL_GAP      = 64,
  parameter int TRAIN_TIMEOUT = 100000,
  parameter int LINK_TIMEOUT  = 100000,
  parameter logic [4:0] UP_CODE = 5'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [4:0]        ltssm_state,
  output logic              req_valid,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_rdata,
  output logic              done,
  output logic              err_train_timeout,
  output logic              err_link_timeout
);
  localparam int TMAX  = (TRAIN_TIMEOUT > LINK_TIMEOUT) ? TRAIN_TIMEOUT : LINK_TIMEOUT;
  localparam int TMR_W = $clog2(TMAX + 2);
  localparam int GAP_W = $clog2(POLL_GAP + 1);
  localparam logic [TMR_W-1:0] TRN_LIM  = TMR_W'(TRAIN_TIMEOUT);
  localparam logic [TMR_W-1:0] LNK_LIM  = TMR_W'(LINK_TIMEOUT - 1);
  localparam logic [TMR_W-1:0] TMR_TOP  = {TMR_W{1'b1}};
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(POLL_GAP - 1);
  localparam logic [ADDR_W-1:0] A_CAP = CAP_BASE + ADDR_W'(12);
  localparam logic [ADDR_W-1:0] A_CTL = CAP_BASE + ADDR_W'(16);
  localparam logic [ADDR_W-1:0] A_STA = CAP_BASE + ADDR_W'(18);
  localparam logic [3:0] SPD_BASE = 4'd1;
  localparam int RETRAIN_BIT  = 5;
  localparam int TRAINING_BIT = 11;

  typedef enum logic [3:0] {
    S_CHK, S_RCAP, S_RSTA, S_RCTL, S_WCTL, S_RTRN, S_GAP, S_WLNK, S_FIN
  } st_t;

  st_t               st;
  logic [DATA_W-1:0] ctl_q;
  logic [TMR_W-1:0]  tmr;
  logic [GAP_W-1:0]  gcnt;
  logic              link_up;
  logic [TMR_W-1:0]  tmr_inc;

  assign link_up   = (ltssm_state == UP_CODE);
  assign tmr_inc   = (tmr == TMR_TOP) ? tmr : tmr + 1'b1;
  assign done      = (st == S_FIN);
  assign req_valid = (st == S_RCAP) || (st == S_RSTA) || (st == S_RCTL) ||
                     (st == S_WCTL) || (st == S_RTRN);
  assign req_write = (st == S_WCTL);
  assign req_wdata = ctl_q | (DATA_W'(1) << RETRAIN_BIT);

  always_comb begin
    case (st)
      S_RCAP:         req_addr = A_CAP;
      S_RCTL, S_WCTL: req_addr = A_CTL;
      default:        req_addr = A_STA;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st                <= S_CHK;
      ctl_q             <= '0;
      tmr               <= '0;
      gcnt              <= '0;
      err_train_timeout <= 1'b0;
      err_link_timeout  <= 1'b0;
    end else begin
      case (st)
        S_CHK: st <= link_up ? S_RCAP : S_FIN;
        S_RCAP:
          if (rsp_valid) st <= (rsp_rdata[3:0] > SPD_BASE) ? S_RSTA : S_FIN;
        S_RSTA:
          if (rsp_valid) st <= (rsp_rdata[3:0] == SPD_BASE) ? S_RCTL : S_FIN;
        S_RCTL:
          if (rsp_valid) begin
            ctl_q <= rsp_rdata;
            st    <= S_WCTL;
          end
        S_WCTL:
          if (rsp_valid) begin
            tmr <= '0;
            st  <= S_RTRN;
          end
        S_RTRN: begin
          tmr <= tmr_inc;
          if (rsp_valid) begin
            if (!rsp_rdata[TRAINING_BIT]) begin
              tmr <= '0;
              st  <= S_WLNK;
            end else if (tmr >= TRN_LIM) begin
              err_train_timeout <= 1'b1;
              tmr <= '0;
              st  <= S_WLNK;
            end else begin
              gcnt <= '0;
              st   <= S_GAP;
            end
          end
        end
        S_GAP: begin
          tmr  <= tmr_inc;
          gcnt <= gcnt + 1'b1;
          if (gcnt >= GAP_LAST) st <= S_RTRN;
        end
        S_WLNK:
          if (link_up) st <= S_FIN;
          else if (tmr >= LNK_LIM) begin
            err_link_timeout <= 1'b1;
            st <= S_FIN;
          end else tmr <= tmr_inc;
        S_FIN: if (start) st <= S_CHK;
        default: st <= S_FIN;
      endcase
    end
  end
endmodule

// File: rtl/link_retrain_seq_chk.sv
module link_retrain_seq_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [4:0]        ltssm_state,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic              done,
  input logic              err_train_timeout,
  input logic              err_link_timeout
);
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !rsp_valid |=> req_valid && $stable(req_addr) &&
    $stable(req_write) && $stable(req_wdata));

  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid);

  assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

  assert_linkdown_skip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done && start && ltssm_state != 5'h0F |=> !req_valid);

  assert_err_train_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_train_timeout |=> err_train_timeout);

  assert_err_link_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_link_timeout |=> err_link_timeout);
endmodule

bind link_retrain_seq link_retrain_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ltssm_state(ltssm_state),
  .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
  .req_wdata(req_wdata), .rsp_valid(rsp_valid), .done(done),
  .err_train_timeout(err_train_timeout), .err_link_timeout(err_link_timeout)
);

// File: tb/tb_link_retrain_seq.sv
module tb_link_retrain_seq;
  localparam int GAP = 4, TTO = 40, LTO = 30;
  localparam logic [11:0] A_CAP = 12'h08C, A_CTL = 12'h090, A_STA = 12'h092;

  logic clk = 0, rst_n = 0, start = 0;
  logic [4:0] ltssm_state = 5'h0F;
  logic req_valid, req_write, rsp_valid = 0, done, err_tr, err_lk;
  logic [11:0] req_addr;
  logic [15:0] req_wdata, rsp_rdata = 0;

  always #4 clk = ~clk;

  link_retrain_seq #(.CAP_BASE(12'h080), .POLL_GAP(GAP), .TRAIN_TIMEOUT(TTO),
                     .LINK_TIMEOUT(LTO)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ltssm_state(ltssm_state),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .done(done), .err_train_timeout(err_tr), .err_link_timeout(err_lk));

  typedef struct packed { logic wr; logic [11:0] addr; logic [15:0] data; } txn_t;
  txn_t expq[$];
  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit tol_sta = 0;
  int extra_sta = 0;
  logic [15:0] cap_v, sta_v, ctl_v;
  int k_cfg = 0, train_left = 0;
  logic [4:0] lt_after = 5'h0F;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // responder and monitor: pops expected accesses and compares
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && req_valid) begin
        logic w; logic [11:0] a; logic [15:0] d;
        w = req_write; a = req_addr; d = req_wdata;
        if (expq.size() == 0) begin
          if (tol_sta && !w && a == A_STA) extra_sta++;
          else chk(0, cur_req, "unexpected access addr", int'(a), 0);
        end else begin
          txn_t e;
          e = expq.pop_front();
          chk(w == e.wr, cur_req, "access direction", int'(w), int'(e.wr));
          chk(a == e.addr, cur_req, "access address", int'(a), int'(e.addr));
          if (e.wr) chk(d == e.data, "R5", "write data", int'(d), int'(e.data));
        end
        if (w) begin
          train_left = k_cfg;
          ltssm_state = lt_after;
        end
        for (int i = 0; i < 2; i++) begin
          @(negedge clk);
          chk(req_valid && req_addr == a && req_write == w && req_wdata == d,
              "R10", "request held", int'(req_addr), int'(a));
        end
        if (a == A_CAP) rsp_rdata = cap_v;
        else if (a == A_CTL) rsp_rdata = ctl_v;
        else begin
          rsp_rdata = sta_v | ((train_left > 0) ? 16'h0800 : 16'h0000);
          if (train_left > 0) train_left--;
        end
        rsp_valid = 1;
        @(negedge clk);
        rsp_valid = 0;
      end
    end
  end

  // driver: configures the register model and pushes the expected accesses
  task automatic setup(input string req, input logic [15:0] cap, input logic [15:0] sta,
                       input logic [15:0] ctl, input int k, input logic [4:0] lt0,
                       input logic [4:0] lt1, input int kind, input bit tol);
    cur_req = req; cap_v = cap; sta_v = sta; ctl_v = ctl; k_cfg = k;
    train_left = 0; ltssm_state = lt0; lt_after = lt1; tol_sta = tol; extra_sta = 0;
    if (kind >= 1) expq.push_back({1'b0, A_CAP, 16'h0});
    if (kind >= 2) expq.push_back({1'b0, A_STA, 16'h0});
    if (kind >= 3) begin
      expq.push_back({1'b0, A_CTL, 16'h0});
      expq.push_back({1'b1, A_CTL, ctl | 16'h0020});
      if (!tol) for (int i = 0; i <= k; i++) expq.push_back({1'b0, A_STA, 16'h0});
    end
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(done, cur_req, "done raised", int'(done), 1);
    chk(expq.size() == 0, cur_req, "expected accesses left", expq.size(), 0);
  endtask

  task automatic kick(output int n);
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    chk(!done, "R9", "done low after start", int'(done), 0);
    wait_done(n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    // auto run after reset, full retrain with two busy polls
    setup("R1", 16'h0003, 16'h0001, 16'h0040, 2, 5'h0F, 5'h0F, 3, 0);
    repeat (3) @(negedge clk);
    chk(!done && !req_valid && !err_tr && !err_lk, "R9", "reset state",
        {done, req_valid, err_tr, err_lk}, 0);
    rst_n = 1;
    wait_done(n);
    chk(!err_tr && !err_lk, "R6", "no errors", {err_tr, err_lk}, 0);

    setup("R3", 16'h0001, 16'h0001, 16'h0000, 0, 5'h0F, 5'h0F, 1, 0);
    kick(n);
    setup("R3", 16'h0000, 16'h0001, 16'h0000, 0, 5'h0F, 5'h0F, 1, 0);
    kick(n);
    setup("R4", 16'h0002, 16'h0002, 16'h0000, 0, 5'h0F, 5'h0F, 2, 0);
    kick(n);

    setup("R2", 16'h0003, 16'h0001, 16'h0000, 0, 5'h11, 5'h11, 0, 0);
    kick(n);
    chk(n == 1, "R2", "link-down run length", n, 1);

    // stray start during a run; poll spacing
    setup("R1", 16'h0002, 16'h0001, 16'h0043, 3, 5'h0F, 5'h0F, 3, 0);
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    repeat (10) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    wait_done(n);
    chk(n >= 3 * GAP, "R6", "poll spacing lower bound", n, 3 * GAP);
    repeat (20) @(negedge clk);
    chk(done && expq.size() == 0, "R1", "no rerun from stray start", int'(done), 1);

    setup("R5", 16'h0004, 16'h0001, 16'h0020, 0, 5'h0F, 5'h0F, 3, 0);
    kick(n);

    setup("R7", 16'h0002, 16'h0001, 16'h0000, 1000, 5'h0F, 5'h0F, 3, 1);
    kick(n);
    chk(err_tr, "R7", "training timeout flag", int'(err_tr), 1);
    chk(!err_lk, "R7", "link flag clear", int'(err_lk), 0);
    chk(n >= TTO, "R7", "timeout length", n, TTO);
    chk(extra_sta >= 2, "R7", "status polls", extra_sta, 2);

    setup("R9", 16'h0002, 16'h0001, 16'h0000, 0, 5'h0F, 5'h0F, 3, 0);
    kick(n);
    chk(err_tr, "R9", "training flag sticky", int'(err_tr), 1);

    setup("R8", 16'h0002, 16'h0001, 16'h0000, 0, 5'h0F, 5'h0B, 3, 0);
    kick(n);
    chk(err_lk, "R8", "link timeout flag", int'(err_lk), 1);
    chk(n >= LTO, "R8", "link wait length", n, LTO);

    setup("R9", 16'h0002, 16'h0001, 16'h0000, 0, 5'h03, 5'h03, 0, 0);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    wait_done(n);
    chk(!err_tr && !err_lk, "R9", "flags cleared by reset", {err_tr, err_lk}, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule